// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block sits between a host-filled command queue and an I2C bit engine. The host writes 11-bit command words. Each word asks for one of five things: a start with an address byte, one byte to transmit, a run of 1 to 256 bytes to receive, the same run received but thrown away, or a stop. The sequencer pops each word and hands the bit engine one byte-level operation at a time. It steps the byte counter of each receive command. Received bytes go into a small receive queue. The host reads that queue as a data byte with an empty indicator beside it.

The sequencer decides the acknowledge for every received byte. A read can be longer than one command's count when the host queues several receive commands in a row. The last byte of one command is acknowledged when the next queued command is also a receive, so the target keeps sending. If the queue is empty when that last byte completes, the byte gets a NACK and an error flag is set. A target NAK on an address or a transmitted byte makes the sequencer drop queued commands up to the next stop and then close the bus itself. Arbitration loss and pin-low timeout come in from the bit engine and are recorded as sticky flags.

Top module: `i2c_cmd_sequencer`

## Requirements
- R1: A command word carries the operation in bits [10:8] (000 transmit, 001 receive, 010 stop, 011 receive-and-discard, 100 start) and its argument in bits [7:0]. Commands run strictly in queue order. The command queue holds 4 words, with `cmd_full` and `cmd_empty` outputs. A write while full is dropped.
- R2: A start command passes its argument unchanged on `eng_data`, with the target address in bits [7:1] and the direction in bit 0 (1 = read). `eng_op` is 0 (start) when the bus is free and 1 (repeated start) when it is held. `bus_held` goes high when a start completes and low when a stop (`eng_op` 4) completes.
- R3: A transmit command presents its byte on `eng_data` with `eng_op` 2.
- R4: A receive or discard command with argument N makes the engine clock in N+1 bytes (1 to 256) under `eng_op` 3. Bytes from receive commands enter the receive queue in arrival order. Bytes from discard commands are never stored.
- R5: `eng_nack` is 0 for every byte of a receive command except the last. For the last byte it is 0 when the command at the head of the queue is a receive or discard, and 1 otherwise.
- R6: If the last byte of a receive command completes while the command queue is empty, that byte gets a NACK and flag bit 2 is set.
- R7: A stored byte that arrives while the 4-entry receive queue is full is dropped and sets flag bit 2. The engine is never held back by this.
- R8: `rx_rd_data` is {empty, byte}: bit 8 is 1 when the receive queue has no data. `rx_rd_en` pops one entry when the queue is not empty.
- R9: A NAK (`eng_nak_in`) at the completion of a start or transmit sets flag bit 0. The sequencer then drops queued commands up to and including the next stop and issues a stop. If the queue runs empty first, it issues the stop at once.
- R10: `arb_lost` sets flag bit 1. If an operation is in progress, it is abandoned: `eng_valid` and `bus_held` are low after the next clock edge.
- R11: `pin_timeout` sets flag bit 3.
- R12: Every flag bit stays set until a 1 is written to the same bit of `flag_clr`.
- R13: After reset both queues are empty, all flags are 0, `eng_valid` is 0 and `bus_held` is 0.
- R14: While `eng_valid` is high, `eng_op` and `eng_data` stay stable until the engine pulses `eng_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr_en | input | 1 | Push one command word |
| cmd_wr_data | input | 11 | Command word: operation [10:8], argument [7:0] |
| cmd_full | output | 1 | Command queue full |
| cmd_empty | output | 1 | Command queue empty |
| rx_rd_en | input | 1 | Pop one received byte |
| rx_rd_data | output | 9 | {empty indicator, data byte} |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| eng_valid | output | 1 | Operation offered to the bit engine |
| eng_op | output | 3 | 0 start, 1 repeated start, 2 transmit, 3 receive, 4 stop |
| eng_data | output | 8 | Address or transmit byte |
| eng_nack | output | 1 | Acknowledge bit for the current received byte (1 = NACK) |
| eng_done | input | 1 | One-cycle pulse: operation or received byte finished |
| eng_nak_in | input | 1 | Target answered NAK; valid with eng_done |
| eng_rx_byte | input | 8 | Received byte; valid with eng_done |
| arb_lost | input | 1 | Arbitration lost, from the bit engine |
| pin_timeout | input | 1 | SCL or SDA held low too long, from the bit engine |
| flags | output | 4 | Sticky: bit0 NAK, bit1 arbitration, bit2 queue error, bit3 timeout |
| flag_clr | input | 4 | Write-1-to-clear for flags |
| bus_held | output | 1 | Bus is owned between a start and a stop |

## Verification
A command written on edge k shows as `eng_valid` after edge k+2: one edge to enter the queue and one to be popped and issued. Flags, the stored byte and `bus_held` change on the edge that consumes `eng_done`. `eng_nack` is combinational and is valid while `eng_done` is high. The bench's engine model drives `eng_done` at a falling edge and samples `eng_nack` a quarter period later, before the consuming rising edge. Queue and flag results are read at falling edges once the design has been quiet for several cycles, or exactly one edge after the stimulus for the arbitration abort and the flag clear.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

    localparam int CMD_W     = 11;
    localparam int BYTE_W    = 8;
    localparam int NUM_FLAGS = 4;

    localparam int FLAG_NAK  = 0;
    localparam int FLAG_ARB  = 1;
    localparam int FLAG_FIFO = 2;
    localparam int FLAG_TMO  = 3;

    typedef enum logic [2:0] {
        CMD_TX     = 3'b000,
        CMD_RX     = 3'b001,
        CMD_STOP   = 3'b010,
        CMD_RXDISC = 3'b011,
        CMD_START  = 3'b100
    } cmd_op_e;

    typedef struct packed {
        cmd_op_e            op;
        logic [BYTE_W-1:0]  arg;
    } cmd_word_t;

    typedef enum logic [2:0] {
        ENG_START   = 3'd0,
        ENG_RESTART = 3'd1,
        ENG_TX      = 3'd2,
        ENG_RX      = 3'd3,
        ENG_STOP    = 3'd4
    } eng_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EXEC,
        ST_FLUSH
    } seq_state_e;

    function automatic logic cmd_is_rx(cmd_op_e op);
        return (op == CMD_RX) || (op == CMD_RXDISC);
    endfunction

endpackage

// File: rtl/seq_fifo.sv
module seq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_wr, do_rd;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem[rd_ptr];

    function automatic logic [AW-1:0] next_ptr(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) begin
                mem[wr_ptr] <= wr_data;
                wr_ptr      <= next_ptr(wr_ptr);
            end
            if (do_rd) rd_ptr <= next_ptr(rd_ptr);
            if (do_wr && !do_rd)      count <= count + 1'b1;
            else if (do_rd && !do_wr) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/seq_flags.sv
module seq_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)         flags[i] <= 1'b0;
            else if (set[i]) flags[i] <= 1'b1;
            else if (clr[i]) flags[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import i2c_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cmd_word_t         head,
    input  logic              head_valid,
    output logic              pop,
    output logic              eng_valid,
    output eng_op_e           eng_op,
    output logic [BYTE_W-1:0] eng_data,
    output logic              eng_nack,
    input  logic              eng_done,
    input  logic              eng_nak_in,
    input  logic [BYTE_W-1:0] eng_rx_byte,
    input  logic              arb_lost,
    output logic              rx_push,
    output logic [BYTE_W-1:0] rx_push_data,
    input  logic              rx_full,
    output logic              bus_held,
    output logic              set_nak,
    output logic              set_arb,
    output logic              set_fifo
);
    seq_state_e        state;
    logic [BYTE_W-1:0] cnt;
    logic              discard;

    logic byte_done, rx_byte, rx_last, head_rx;

    assign byte_done    = (state == ST_EXEC) && eng_done && !arb_lost;
    assign rx_byte      = byte_done && (eng_op == ENG_RX);
    assign rx_last      = (cnt == '0);
    assign head_rx      = head_valid && cmd_is_rx(head.op);
    assign eng_nack     = rx_last && !head_rx;
    assign rx_push      = rx_byte && !discard && !rx_full;
    assign rx_push_data = eng_rx_byte;
    assign set_fifo     = (rx_byte && !discard && rx_full) ||
                          (rx_byte && rx_last && !head_valid);
    assign set_nak      = byte_done && (eng_op != ENG_RX) && (eng_op != ENG_STOP) && eng_nak_in;
    assign set_arb      = arb_lost;
    assign pop          = ((state == ST_IDLE) || (state == ST_FLUSH)) && head_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            eng_valid <= 1'b0;
            eng_op    <= ENG_START;
            eng_data  <= '0;
            cnt       <= '0;
            discard   <= 1'b0;
            bus_held  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (head_valid) begin
                        case (head.op)
                            CMD_START: begin
                                eng_op    <= bus_held ? ENG_RESTART : ENG_START;
                                eng_data  <= head.arg;
                                eng_valid <= 1'b1;
                                state     <= ST_EXEC;
                            end
                            CMD_TX: begin
                                eng_op    <= ENG_TX;
                                eng_data  <= head.arg;
                                eng_valid <= 1'b1;
                                state     <= ST_EXEC;
                            end
                            CMD_RX, CMD_RXDISC: begin
                                eng_op    <= ENG_RX;
                                cnt       <= head.arg;
                                discard   <= (head.op == CMD_RXDISC);
                                eng_valid <= 1'b1;
                                state     <= ST_EXEC;
                            end
                            CMD_STOP: begin
                                eng_op    <= ENG_STOP;
                                eng_valid <= 1'b1;
                                state     <= ST_EXEC;
                            end
                            default: ;
                        endcase
                    end
                end
                ST_EXEC: begin
                    if (arb_lost) begin
                        eng_valid <= 1'b0;
                        bus_held  <= 1'b0;
                        state     <= ST_IDLE;
                    end else if (eng_done) begin
                        case (eng_op)
                            ENG_START, ENG_RESTART, ENG_TX: begin
                                eng_valid <= 1'b0;
                                if (eng_op != ENG_TX) bus_held <= 1'b1;
                                state <= eng_nak_in ? ST_FLUSH : ST_IDLE;
                            end
                            ENG_RX: begin
                                if (rx_last) begin
                                    eng_valid <= 1'b0;
                                    state     <= ST_IDLE;
                                end else begin
                                    cnt <= cnt - 1'b1;
                                end
                            end
                            default: begin
                                eng_valid <= 1'b0;
                                bus_held  <= 1'b0;
                                state     <= ST_IDLE;
                            end
                        endcase
                    end
                end
                ST_FLUSH: begin
                    if (!head_valid || head.op == CMD_STOP) begin
                        eng_op    <= ENG_STOP;
                        eng_valid <= 1'b1;
                        state     <= ST_EXEC;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/i2c_cmd_sequencer.sv
module i2c_cmd_sequencer
    import i2c_seq_pkg::*;
#(
    parameter int CMD_DEPTH = 4,
    parameter int RX_DEPTH  = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_wr_en,
    input  logic [CMD_W-1:0]     cmd_wr_data,
    output logic                 cmd_full,
    output logic                 cmd_empty,
    input  logic                 rx_rd_en,
    output logic [BYTE_W:0]      rx_rd_data,
    output logic                 rx_full,
    output logic                 rx_empty,
    output logic                 eng_valid,
    output logic [2:0]           eng_op,
    output logic [BYTE_W-1:0]    eng_data,
    output logic                 eng_nack,
    input  logic                 eng_done,
    input  logic                 eng_nak_in,
    input  logic [BYTE_W-1:0]    eng_rx_byte,
    input  logic                 arb_lost,
    input  logic                 pin_timeout,
    output logic [NUM_FLAGS-1:0] flags,
    input  logic [NUM_FLAGS-1:0] flag_clr,
    output logic                 bus_held
);
    logic [CMD_W-1:0]     cmd_q;
    cmd_word_t            cmd_head;
    logic                 cmd_pop;
    logic                 rx_push;
    logic [BYTE_W-1:0]    rx_push_data, rx_q;
    logic                 set_nak, set_arb, set_fifo;
    logic [NUM_FLAGS-1:0] flag_set;
    eng_op_e              op_e;

    assign cmd_head = cmd_word_t'(cmd_q);
    assign eng_op   = op_e;

    seq_fifo #(.W(CMD_W), .DEPTH(CMD_DEPTH)) u_cmdq (
        .clk(clk), .rst(rst),
        .wr_en(cmd_wr_en), .wr_data(cmd_wr_data),
        .rd_en(cmd_pop), .rd_data(cmd_q),
        .full(cmd_full), .empty(cmd_empty)
    );

    seq_fifo #(.W(BYTE_W), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst(rst),
        .wr_en(rx_push), .wr_data(rx_push_data),
        .rd_en(rx_rd_en), .rd_data(rx_q),
        .full(rx_full), .empty(rx_empty)
    );

    assign rx_rd_data = {rx_empty, rx_q};

    seq_ctrl u_ctrl (
        .clk(clk), .rst(rst),
        .head(cmd_head), .head_valid(!cmd_empty), .pop(cmd_pop),
        .eng_valid(eng_valid), .eng_op(op_e), .eng_data(eng_data), .eng_nack(eng_nack),
        .eng_done(eng_done), .eng_nak_in(eng_nak_in), .eng_rx_byte(eng_rx_byte),
        .arb_lost(arb_lost),
        .rx_push(rx_push), .rx_push_data(rx_push_data), .rx_full(rx_full),
        .bus_held(bus_held),
        .set_nak(set_nak), .set_arb(set_arb), .set_fifo(set_fifo)
    );

    always_comb begin
        flag_set            = '0;
        flag_set[FLAG_NAK]  = set_nak;
        flag_set[FLAG_ARB]  = set_arb;
        flag_set[FLAG_FIFO] = set_fifo;
        flag_set[FLAG_TMO]  = pin_timeout;
    end

    seq_flags #(.N(NUM_FLAGS)) u_flags (
        .clk(clk), .rst(rst),
        .set(flag_set), .clr(flag_clr), .flags(flags)
    );
endmodule

// File: rtl/i2c_seq_chk.sv
module i2c_seq_chk
    import i2c_seq_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 cmd_empty,
    input logic                 rx_full,
    input logic                 rx_empty,
    input logic                 eng_valid,
    input logic [2:0]           eng_op,
    input logic [BYTE_W-1:0]    eng_data,
    input logic                 eng_nack,
    input logic                 eng_done,
    input logic                 eng_nak_in,
    input logic                 arb_lost,
    input logic                 pin_timeout,
    input logic [NUM_FLAGS-1:0] flags,
    input logic [NUM_FLAGS-1:0] flag_clr,
    input logic                 bus_held
);
    // R14: offered operation is held until the engine finishes it
    assert_op_hold_R14: assert property (@(posedge clk) disable iff (rst)
        (eng_valid && !eng_done && !arb_lost) |=> (eng_valid && $stable(eng_op) && $stable(eng_data)));

    // R12: a set flag only clears through flag_clr
    assert_flags_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flags & $past(flags & ~flag_clr)) == $past(flags & ~flag_clr)));

    // R6: last receive byte with nothing queued raises the queue-error flag
    assert_underflow_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (eng_valid && eng_done && !arb_lost && eng_op == 3'(ENG_RX) && eng_nack && cmd_empty)
        |=> flags[FLAG_FIFO]);

    // R9: target NAK on start or transmit raises the NAK flag
    assert_nak_flag_R9: assert property (@(posedge clk) disable iff (rst)
        (eng_valid && eng_done && !arb_lost && eng_nak_in &&
         (eng_op == 3'(ENG_START) || eng_op == 3'(ENG_RESTART) || eng_op == 3'(ENG_TX)))
        |=> flags[FLAG_NAK]);

    // R2: start only on a free bus, repeated start only on a held bus
    assert_start_kind_R2: assert property (@(posedge clk) disable iff (rst)
        (eng_valid && (eng_op == 3'(ENG_START) || eng_op == 3'(ENG_RESTART)))
        |-> (bus_held == (eng_op == 3'(ENG_RESTART))));

    // R2: completed stop releases the bus
    assert_stop_release_R2: assert property (@(posedge clk) disable iff (rst)
        (eng_valid && eng_done && eng_op == 3'(ENG_STOP)) |=> !bus_held);

    // R10: arbitration loss aborts and is recorded
    assert_arb_abort_R10: assert property (@(posedge clk) disable iff (rst)
        arb_lost |=> (!eng_valid && !bus_held && flags[FLAG_ARB]));

    // R11: timeout is recorded
    assert_timeout_flag_R11: assert property (@(posedge clk) disable iff (rst)
        pin_timeout |=> flags[FLAG_TMO]);

    // R8: receive queue status is coherent
    assert_rx_status_R8: assert property (@(posedge clk) disable iff (rst)
        !(rx_full && rx_empty));
endmodule

bind i2c_cmd_sequencer i2c_seq_chk u_chk (
    .clk(clk), .rst(rst), .cmd_empty(cmd_empty),
    .rx_full(rx_full), .rx_empty(rx_empty),
    .eng_valid(eng_valid), .eng_op(eng_op), .eng_data(eng_data), .eng_nack(eng_nack),
    .eng_done(eng_done), .eng_nak_in(eng_nak_in), .arb_lost(arb_lost),
    .pin_timeout(pin_timeout), .flags(flags), .flag_clr(flag_clr), .bus_held(bus_held)
);

// File: tb/tb_i2c_cmd_sequencer.sv
module tb_i2c_cmd_sequencer;
    localparam int CLK_P = 10;

    localparam logic [2:0] C_TX = 3'b000, C_RX = 3'b001, C_STOP = 3'b010,
                           C_DISC = 3'b011, C_START = 3'b100;
    localparam logic [2:0] OP_START = 3'd0, OP_RESTART = 3'd1, OP_TX = 3'd2,
                           OP_RX = 3'd3, OP_STOP = 3'd4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_wr_en = 1'b0;
    logic [10:0] cmd_wr_data = '0;
    logic        cmd_full, cmd_empty;
    logic        rx_rd_en = 1'b0;
    logic [8:0]  rx_rd_data;
    logic        rx_full, rx_empty;
    logic        eng_valid;
    logic [2:0]  eng_op;
    logic [7:0]  eng_data;
    logic        eng_nack;
    logic        eng_done = 1'b0;
    logic        eng_nak_in = 1'b0;
    logic [7:0]  eng_rx_byte = '0;
    logic        arb_lost = 1'b0;
    logic        pin_timeout = 1'b0;
    logic [3:0]  flags;
    logic [3:0]  flag_clr = '0;
    logic        bus_held;

    always #(CLK_P/2) clk = ~clk;

    i2c_cmd_sequencer dut (
        .clk(clk), .rst(rst),
        .cmd_wr_en(cmd_wr_en), .cmd_wr_data(cmd_wr_data),
        .cmd_full(cmd_full), .cmd_empty(cmd_empty),
        .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data),
        .rx_full(rx_full), .rx_empty(rx_empty),
        .eng_valid(eng_valid), .eng_op(eng_op), .eng_data(eng_data), .eng_nack(eng_nack),
        .eng_done(eng_done), .eng_nak_in(eng_nak_in), .eng_rx_byte(eng_rx_byte),
        .arb_lost(arb_lost), .pin_timeout(pin_timeout),
        .flags(flags), .flag_clr(flag_clr), .bus_held(bus_held)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // engine model state
    int         lat = 2;
    int         nak_at = -1;
    int         tx_seen = 0;
    int         hold_err = 0;
    logic [7:0] rx_val = 8'h10;
    int         log_n = 0;
    logic [2:0] op_log   [512];
    logic [7:0] data_log [512];
    logic       nack_log [512];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // bit engine model
    initial begin : engine
        logic [2:0] op0;
        logic [7:0] d0;
        bit alive;
        forever begin
            @(negedge clk);
            if (!rst && eng_valid) begin
                alive = 1;
                op0 = eng_op;
                d0  = eng_data;
                for (int i = 0; i < lat; i++) begin
                    @(negedge clk);
                    if (!eng_valid) begin
                        alive = 0;
                        break;
                    end
                    if (eng_op != op0 || eng_data != d0) hold_err++;
                end
                if (alive) begin
                    eng_done    = 1'b1;
                    eng_rx_byte = rx_val;
                    eng_nak_in  = (op0 != OP_RX && op0 != OP_STOP) && (tx_seen == nak_at);
                    if (op0 != OP_RX && op0 != OP_STOP) tx_seen++;
                    #(CLK_P/4);
                    op_log[log_n]   = op0;
                    data_log[log_n] = d0;
                    nack_log[log_n] = eng_nack;
                    log_n++;
                    if (op0 == OP_RX) rx_val++;
                    @(negedge clk);
                    eng_done   = 1'b0;
                    eng_nak_in = 1'b0;
                end
            end
        end
    end

    // all host tasks start and end at a falling edge
    task automatic push(input logic [2:0] op, input logic [7:0] arg);
        while (cmd_full) @(negedge clk);
        cmd_wr_en   = 1'b1;
        cmd_wr_data = {op, arg};
        @(negedge clk);
        cmd_wr_en   = 1'b0;
    endtask

    task automatic poke(input logic [2:0] op, input logic [7:0] arg);
        cmd_wr_en   = 1'b1;
        cmd_wr_data = {op, arg};
        @(negedge clk);
        cmd_wr_en   = 1'b0;
    endtask

    task automatic pop_rx(output logic [8:0] v);
        v = rx_rd_data;
        if (!v[8]) begin
            rx_rd_en = 1'b1;
            @(negedge clk);
            rx_rd_en = 1'b0;
        end
    endtask

    task automatic wait_quiet();
        int q = 0;
        while (q < 8) begin
            @(negedge clk);
            q = (cmd_empty && !eng_valid) ? q + 1 : 0;
        end
    endtask

    task automatic clear_flags();
        flag_clr = 4'hF;
        @(negedge clk);
        flag_clr = 4'h0;
        chk(flags == 4'h0, "R12 flags cleared by write-1", flags, 0);
    endtask

    function automatic bit exp_nack(int k, int total);
        return (k == total - 1);
    endfunction

    task automatic check_op(input int idx, input logic [2:0] op, input logic [7:0] d,
                            input bit chk_data, input string req);
        chk(op_log[idx] == op, req, op_log[idx], op);
        if (chk_data) chk(data_log[idx] == d, req, data_log[idx], d);
    endtask

    initial begin : main
        logic [8:0] v;
        logic [7:0] base;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        chk(cmd_empty && !cmd_full, "R13 command queue empty after reset", {cmd_full, cmd_empty}, 1);
        chk(rx_empty && rx_rd_data[8], "R13 R8 receive queue empty flag after reset", rx_rd_data, 9'h100);
        chk(flags == 4'h0, "R13 flags after reset", flags, 0);
        chk(!eng_valid && !bus_held, "R13 engine idle after reset", {eng_valid, bus_held}, 0);

        // write transfer, queue fill, write while full dropped
        lat = 8; log_n = 0;
        push(C_START, 8'hA0);
        push(C_TX, 8'h5A);
        push(C_TX, 8'hC3);
        push(C_TX, 8'h3C);
        push(C_STOP, 8'h00);
        chk(cmd_full == 1'b1, "R1 command queue full at four entries", cmd_full, 1);
        poke(C_TX, 8'hEE);
        wait_quiet();
        chk(log_n == 5, "R1 write while full dropped", log_n, 5);
        check_op(0, OP_START, 8'hA0, 1, "R2 start with address payload");
        check_op(1, OP_TX, 8'h5A, 1, "R3 transmit byte 1");
        check_op(2, OP_TX, 8'hC3, 1, "R3 transmit byte 2");
        check_op(3, OP_TX, 8'h3C, 1, "R1 transmit in queue order");
        check_op(4, OP_STOP, 8'h00, 0, "R2 stop");
        chk(bus_held == 1'b0, "R2 bus released after stop", bus_held, 0);

        // repeated start, chained receive/discard/receive
        lat = 2; log_n = 0; base = rx_val;
        push(C_START, 8'hA0);
        push(C_TX, 8'h01);
        push(C_START, 8'hA1);
        push(C_RX, 8'd1);
        push(C_DISC, 8'd1);
        push(C_RX, 8'd1);
        push(C_STOP, 8'h00);
        wait_quiet();
        chk(log_n == 10, "R4 chained read byte count", log_n, 10);
        check_op(2, OP_RESTART, 8'hA1, 1, "R2 repeated start on held bus");
        for (int k = 0; k < 6; k++) begin
            chk(op_log[3+k] == OP_RX, "R4 receive operation", op_log[3+k], OP_RX);
            chk(nack_log[3+k] == exp_nack(k, 6), "R5 ack lookahead across chained commands",
                nack_log[3+k], exp_nack(k, 6));
        end
        check_op(9, OP_STOP, 8'h00, 0, "R2 stop after read");
        chk(rx_full == 1'b1 && flags == 4'h0, "R4 four stored bytes, no error", {rx_full, flags}, 5'h10);
        for (int k = 0; k < 4; k++) begin
            logic [7:0] e;
            e = base + 8'((k < 2) ? k : k + 2);
            pop_rx(v);
            chk(v == {1'b0, e}, "R4 discard bytes not stored", v, {1'b0, e});
        end
        pop_rx(v);
        chk(v[8] == 1'b1, "R8 empty indicator after drain", v[8], 1);

        // underflow: receive with nothing queued behind it
        log_n = 0;
        push(C_START, 8'hA1);
        push(C_RX, 8'd2);
        wait_quiet();
        chk(log_n == 4, "R4 three bytes from count 2", log_n, 4);
        chk(nack_log[3] == 1'b1 && nack_log[2] == 1'b0, "R6 nack on starved last byte",
            {nack_log[2], nack_log[3]}, 1);
        chk(flags == 4'b0100, "R6 underflow flag", flags, 4'b0100);
        repeat (5) @(negedge clk);
        chk(flags == 4'b0100, "R12 flag sticky", flags, 4'b0100);
        clear_flags();
        push(C_STOP, 8'h00);
        wait_quiet();
        chk(bus_held == 1'b0, "R2 bus released", bus_held, 0);
        repeat (3) pop_rx(v);

        // single byte receive
        log_n = 0;
        push(C_START, 8'hA1);
        push(C_RX, 8'd0);
        push(C_STOP, 8'h00);
        wait_quiet();
        chk(log_n == 3 && nack_log[1] == 1'b1, "R5 single-byte read nacked", {log_n, nack_log[1]}, 1);
        pop_rx(v);

        // overrun
        log_n = 0; base = rx_val;
        push(C_START, 8'hA1);
        push(C_RX, 8'd5);
        push(C_STOP, 8'h00);
        wait_quiet();
        chk(log_n == 8, "R7 engine not stalled by full queue", log_n, 8);
        chk(flags[2] == 1'b1, "R7 overrun flag", flags, 4'b0100);
        for (int k = 0; k < 4; k++) begin
            pop_rx(v);
            chk(v == {1'b0, base + 8'(k)}, "R7 first four bytes kept", v, {1'b0, base + 8'(k)});
        end
        pop_rx(v);
        chk(v[8] == 1'b1, "R7 extra bytes dropped", v, 9'h100);
        clear_flags();

        // NAK with a stop queued, command after the stop still runs
        log_n = 0; tx_seen = 0; nak_at = 1;
        push(C_START, 8'hA0);
        push(C_TX, 8'h11);
        push(C_TX, 8'h22);
        push(C_STOP, 8'h00);
        push(C_TX, 8'h77);
        wait_quiet();
        chk(log_n == 4, "R9 flush up to stop", log_n, 4);
        check_op(1, OP_TX, 8'h11, 1, "R9 nacked byte");
        check_op(2, OP_STOP, 8'h00, 0, "R9 stop after nak");
        check_op(3, OP_TX, 8'h77, 1, "R9 command after stop kept");
        chk(flags == 4'b0001, "R9 nak flag", flags, 1);
        clear_flags();

        // NAK with queue running empty
        log_n = 0; tx_seen = 0; nak_at = 1;
        push(C_START, 8'hA0);
        push(C_TX, 8'h55);
        wait_quiet();
        nak_at = -1;
        chk(log_n == 3 && op_log[2] == OP_STOP, "R9 stop issued on empty queue", op_log[2], OP_STOP);
        chk(bus_held == 1'b0 && flags[0], "R9 bus closed after nak", {bus_held, flags[0]}, 1);
        clear_flags();

        // arbitration loss
        lat = 6; log_n = 0;
        push(C_START, 8'hA0);
        push(C_TX, 8'h99);
        push(C_STOP, 8'h00);
        while (!(eng_valid && eng_op == OP_TX)) @(negedge clk);
        arb_lost = 1'b1;
        @(negedge clk);
        arb_lost = 1'b0;
        chk(!eng_valid && !bus_held, "R10 abort on arbitration loss", {eng_valid, bus_held}, 0);
        chk(flags[1] == 1'b1, "R10 arbitration flag", flags, 4'b0010);
        wait_quiet();
        chk(op_log[log_n-1] == OP_STOP, "R10 next command runs", op_log[log_n-1], OP_STOP);
        clear_flags();

        // timeout input
        pin_timeout = 1'b1;
        @(negedge clk);
        pin_timeout = 1'b0;
        chk(flags == 4'b1000, "R11 timeout flag", flags, 4'b1000);
        clear_flags();

        // 256-byte discard boundary
        lat = 1; log_n = 0;
        push(C_START, 8'hA1);
        push(C_DISC, 8'hFF);
        push(C_STOP, 8'h00);
        wait_quiet();
        begin
            int nacks = 0;
            for (int k = 1; k <= 256; k++) nacks += nack_log[k];
            chk(log_n == 258, "R4 256 bytes from count 255", log_n, 258);
            chk(nacks == 1 && nack_log[256] == 1'b1, "R5 only final byte nacked", nacks, 1);
        end
        chk(rx_empty == 1'b1 && flags == 4'h0, "R4 discard stores nothing", {rx_empty, flags}, 5'h10);

        // constrained random reads and writes
        void'($urandom(32'd4242));
        for (int it = 0; it < 12; it++) begin
            int c1, c2, total, sto, lim;
            bit d1, d2;
            logic [7:0] t1, t2;
            logic [7:0] exp_st [4];
            c1 = $urandom_range(0, 4);
            c2 = $urandom_range(0, 4);
            d1 = 1'($urandom_range(0, 1));
            d2 = 1'($urandom_range(0, 1));
            t1 = 8'($urandom);
            t2 = 8'($urandom);
            lat = $urandom_range(1, 3);
            log_n = 0;
            push(C_START, 8'hA0);
            push(C_TX, t1);
            push(C_TX, t2);
            push(C_STOP, 8'h00);
            wait_quiet();
            check_op(1, OP_TX, t1, 1, "R3 random transmit byte");
            check_op(2, OP_TX, t2, 1, "R3 random transmit byte");

            log_n = 0; base = rx_val;
            push(C_START, 8'hA1);
            push(d1 ? C_DISC : C_RX, 8'(c1));
            push(d2 ? C_DISC : C_RX, 8'(c2));
            push(C_STOP, 8'h00);
            wait_quiet();
            total = c1 + c2 + 2;
            chk(log_n == total + 2, "R4 random read length", log_n, total + 2);
            sto = 0;
            for (int k = 0; k < total; k++) begin
                bit disc;
                chk(nack_log[k+1] == exp_nack(k, total), "R5 random ack pattern",
                    nack_log[k+1], exp_nack(k, total));
                disc = (k <= c1) ? d1 : d2;
                if (!disc) begin
                    if (sto < 4) exp_st[sto] = base + 8'(k);
                    sto++;
                end
            end
            chk(flags[2] == (sto > 4), "R7 random overrun flag", flags[2], (sto > 4));
            lim = (sto > 4) ? 4 : sto;
            for (int k = 0; k < lim; k++) begin
                pop_rx(v);
                chk(v == {1'b0, exp_st[k]}, "R4 random stored byte", v, {1'b0, exp_st[k]});
            end
            pop_rx(v);
            chk(v[8] == 1'b1, "R8 random drain empty", v[8], 1);
            clear_flags();
        end

        chk(hold_err == 0, "R14 operation stable until done", hold_err, 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R13 run hung actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule